// File: doc/BRIEF.md
# Host Channel Halt Controller

This block retires host transfer channels in an orderly way. Several channels share two request queues, one for non-periodic and one for periodic traffic, and a round-robin arbiter that grants a single channel per clock. Software writes a channel's enable and disable control bits. A disable write removes the channel's normal requests that are still waiting in its class queue. When the enable bit is also written as 1, a disable request is recorded. That request enters the queue only on the channel's own arbitration turn, and only when the queue has room.

The queue heads are retired only while no bus transaction is in progress, so a transaction that has started always completes. When a disable entry is retired, one of two things happens depending on the mode. In DMA mode the channel's sticky halted interrupt is set at once. In slave mode a receive-status entry is posted and the receive-level flag is raised, and the halted interrupt follows only when software pops that channel's status entry. Setting a halted bit clears the channel's enable bit. The mode input is taken in only while every channel is idle.

Top module: `hc_halt_ctrl`

## Requirements
- R1: After reset, every channel is disabled, no halted bit is set, both queues are empty, no status entry is pending, and slave mode is selected (mode_dma_o = 0).
- R2: A write with disable = 1 and enable = 1 pulses flush_o in that cycle. At the same clock edge it removes every normal entry of that channel from its class queue, and the other entries keep their order.
- R3: A write with disable = 1 and enable = 0 removes the channel's normal entries. It writes no disable request, raises no halted bit and leaves the enable bit unchanged.
- R4: A recorded disable request is written into its class queue (dis_wr_np_o or dis_wr_p_o) only in a cycle where that channel holds the grant and the queue is not full. When the queue is full the request waits and the queue count is unchanged.
- R5: No queue head is retired and issue_o stays low while xact_busy_i is 1. A halt never takes effect during a transaction.
- R6: In DMA mode, retiring a channel's disable entry sets that channel's halted bit at the next clock edge.
- R7: In slave mode, retiring a disable entry sets a pending status for the channel and raises rxflvl_o. The halted bit is set only by a stat_pop_i naming that channel. A pop that names a channel with no pending status has no effect.
- R8: In slave mode, a disable-and-enable write whose class queue is full (count 4) at the time of the write is refused. The flush still happens, but the channel is never halted and stays enabled.
- R9: Halted bits are sticky and are cleared by a 1 in the matching bit of halt_clr_i. While a halted bit is set, the channel's enable bit reads 0.
- R10: dma_mode_i is sampled into mode_dma_o only while no channel is enabled, no disable is pending and no status entry is pending.
- R11: The arbiter grants only channels with a pending disable, and at most one disable write happens per cycle.
- R12: Neither queue count ever exceeds the queue depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dma_mode_i | input | 1 | 1 selects DMA behaviour, 0 selects slave behaviour |
| ch_per_i | input | NCH | Per-channel class, 1 = periodic |
| cfg_we_i | input | 1 | Control write strobe |
| cfg_ch_i | input | CHW | Channel addressed by the control write |
| cfg_ena_i | input | 1 | Enable bit value written |
| cfg_dis_i | input | 1 | Disable bit value written |
| post_we_i | input | 1 | Post a normal request for an enabled channel |
| post_ch_i | input | CHW | Channel of the posted request |
| xact_busy_i | input | 1 | A bus transaction is in progress |
| stat_pop_i | input | 1 | Software pops a receive-status entry |
| stat_pop_ch_i | input | CHW | Channel of the popped status entry |
| halt_clr_i | input | NCH | Write-1-to-clear for the halted bits |
| ch_ena_o | output | NCH | Channel enable bits |
| halted_o | output | NCH | Sticky halted interrupts |
| rxflvl_o | output | 1 | A receive-status entry is pending |
| flush_o | output | 1 | Flush of the addressed channel this cycle |
| dis_wr_np_o | output | 1 | Disable request written to the non-periodic queue |
| dis_wr_p_o | output | 1 | Disable request written to the periodic queue |
| issue_o | output | 1 | A normal request is retired from a queue head |
| issue_ch_o | output | CHW | Channel of the retired normal request |
| np_cnt_o | output | CW | Non-periodic queue occupancy |
| p_cnt_o | output | CW | Periodic queue occupancy |
| mode_dma_o | output | 1 | Sampled mode |

## Verification
The disable path is driven with queues that hold entries of the disabled channel mixed with another channel's entries, so a flush that drops too much or too little changes the count seen at the next edge. The same disable is then repeated against a full queue in each mode: DMA must hold the request until a slot frees, and slave must refuse it. Holding the transaction flag high while entries wait separates a halt that respects the in-flight transaction from one that retires early. In slave mode a pop that names the wrong channel and a pop that names the right one tell apart the pop-gated halt and a halt raised directly on retirement. A scoreboard of expected halted channels checks the order of all halt events.

// File: rtl/hc_halt_pkg.sv
package hc_halt_pkg;
    localparam int HC_CHW = 4;

    typedef struct packed {
        logic [HC_CHW-1:0] ch;
        logic              dis;
    } hc_entry_t;
endpackage

// File: rtl/hc_rr_arb.sv
module hc_rr_arb #(
    parameter int N = 4,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] req_i,
    input  logic [W-1:0] ptr_i,
    output logic         gnt_v_o,
    output logic [W-1:0] gnt_o
);
    always_comb begin
        gnt_v_o = 1'b0;
        gnt_o   = '0;
        for (int off = N - 1; off >= 0; off--) begin
            int idx;
            idx = (int'(ptr_i) + off) % N;
            if (req_i[idx]) begin
                gnt_v_o = 1'b1;
                gnt_o   = W'(idx);
            end
        end
    end
endmodule

// File: rtl/hc_req_queue.sv
module hc_req_queue
    import hc_halt_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop_i,
    input  logic              flush_i,
    input  logic [HC_CHW-1:0] flush_ch_i,
    input  logic              push_n_i,
    input  logic [HC_CHW-1:0] push_n_ch_i,
    input  logic              push_d_i,
    input  logic [HC_CHW-1:0] push_d_ch_i,
    output logic              push_d_ok_o,
    output hc_entry_t         head_o,
    output logic [CW-1:0]     cnt_o
);
    typedef struct packed {
        hc_entry_t [DEPTH-1:0] ent;
        logic [CW-1:0]         cnt;
    } q_t;

    q_t q_d, q_q;

    always_comb begin
        hc_entry_t [DEPTH-1:0] a;
        hc_entry_t [DEPTH-1:0] b;
        int n;
        int k;
        a = q_q.ent;
        b = '0;
        n = int'(q_q.cnt);
        k = 0;
        push_d_ok_o = 1'b0;
        // retire the head
        if (pop_i && n != 0) begin
            for (int i = 0; i < DEPTH - 1; i++) a[i] = a[i+1];
            a[DEPTH-1] = '0;
            n = n - 1;
        end
        // drop the flushed channel's normal entries, keep order of the rest
        for (int i = 0; i < DEPTH; i++) begin
            if (i < n && !(flush_i && !a[i].dis && a[i].ch == flush_ch_i)) begin
                for (int j = 0; j < DEPTH; j++) begin
                    if (j == k) b[j] = a[i];
                end
                k = k + 1;
            end
        end
        n = k;
        if (push_n_i && n < DEPTH) begin
            for (int j = 0; j < DEPTH; j++) begin
                if (j == n) b[j] = '{ch: push_n_ch_i, dis: 1'b0};
            end
            n = n + 1;
        end
        if (push_d_i && n < DEPTH) begin
            for (int j = 0; j < DEPTH; j++) begin
                if (j == n) b[j] = '{ch: push_d_ch_i, dis: 1'b1};
            end
            n = n + 1;
            push_d_ok_o = 1'b1;
        end
        q_d.ent = b;
        q_d.cnt = CW'(n);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign head_o = q_q.ent[0];
    assign cnt_o  = q_q.cnt;
endmodule

// File: rtl/hc_halt_ctrl.sv
module hc_halt_ctrl
    import hc_halt_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int DEPTH = 4,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int CW  = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           dma_mode_i,
    input  logic [NCH-1:0] ch_per_i,
    input  logic           cfg_we_i,
    input  logic [CHW-1:0] cfg_ch_i,
    input  logic           cfg_ena_i,
    input  logic           cfg_dis_i,
    input  logic           post_we_i,
    input  logic [CHW-1:0] post_ch_i,
    input  logic           xact_busy_i,
    input  logic           stat_pop_i,
    input  logic [CHW-1:0] stat_pop_ch_i,
    input  logic [NCH-1:0] halt_clr_i,
    output logic [NCH-1:0] ch_ena_o,
    output logic [NCH-1:0] halted_o,
    output logic           rxflvl_o,
    output logic           flush_o,
    output logic           dis_wr_np_o,
    output logic           dis_wr_p_o,
    output logic           issue_o,
    output logic [CHW-1:0] issue_ch_o,
    output logic [CW-1:0]  np_cnt_o,
    output logic [CW-1:0]  p_cnt_o,
    output logic           mode_dma_o
);
    typedef struct packed {
        logic [NCH-1:0] ena;
        logic [NCH-1:0] halted;
        logic [NCH-1:0] dis_pend;
        logic [NCH-1:0] stat_pend;
        logic [CHW-1:0] ptr;
        logic           mode;
    } st_t;

    st_t st_d, st_q;

    logic            cfg_cls, post_cls, gnt_cls;
    logic            gnt_v;
    logic [CHW-1:0]  gnt;
    logic            post_ok, dis_accept;
    logic            pop_p, pop_np, retire, retire_dis;
    hc_entry_t       np_head, p_head, head;
    logic [CW-1:0]   np_cnt, p_cnt, cls_cnt;
    logic            np_dok, p_dok;
    logic [HC_CHW-1:0] cfg_ch_w, post_ch_w, gnt_w;

    assign cfg_ch_w  = HC_CHW'(cfg_ch_i);
    assign post_ch_w = HC_CHW'(post_ch_i);
    assign gnt_w     = HC_CHW'(gnt);

    assign cfg_cls  = ch_per_i[cfg_ch_i];
    assign post_cls = ch_per_i[post_ch_i];
    assign gnt_cls  = ch_per_i[gnt];
    assign cls_cnt  = cfg_cls ? p_cnt : np_cnt;

    assign flush_o    = cfg_we_i && cfg_dis_i;
    assign dis_accept = flush_o && cfg_ena_i && (st_q.mode || cls_cnt != CW'(DEPTH));
    assign post_ok    = post_we_i && st_q.ena[post_ch_i];

    // retirement: periodic queue first, only between transactions
    assign pop_p      = !xact_busy_i && p_cnt != '0;
    assign pop_np     = !xact_busy_i && p_cnt == '0 && np_cnt != '0;
    assign head       = pop_p ? p_head : np_head;
    assign retire     = pop_p || pop_np;
    assign retire_dis = retire && head.dis;
    assign issue_o    = retire && !head.dis;
    assign issue_ch_o = CHW'(head.ch);

    hc_rr_arb #(.N(NCH)) u_arb (
        .req_i   (st_q.dis_pend),
        .ptr_i   (st_q.ptr),
        .gnt_v_o (gnt_v),
        .gnt_o   (gnt)
    );

    hc_req_queue #(.DEPTH(DEPTH)) u_npq (
        .clk         (clk),
        .rst_n       (rst_n),
        .pop_i       (pop_np),
        .flush_i     (flush_o && !cfg_cls),
        .flush_ch_i  (cfg_ch_w),
        .push_n_i    (post_ok && !post_cls),
        .push_n_ch_i (post_ch_w),
        .push_d_i    (gnt_v && !gnt_cls),
        .push_d_ch_i (gnt_w),
        .push_d_ok_o (np_dok),
        .head_o      (np_head),
        .cnt_o       (np_cnt)
    );

    hc_req_queue #(.DEPTH(DEPTH)) u_pq (
        .clk         (clk),
        .rst_n       (rst_n),
        .pop_i       (pop_p),
        .flush_i     (flush_o && cfg_cls),
        .flush_ch_i  (cfg_ch_w),
        .push_n_i    (post_ok && post_cls),
        .push_n_ch_i (post_ch_w),
        .push_d_i    (gnt_v && gnt_cls),
        .push_d_ch_i (gnt_w),
        .push_d_ok_o (p_dok),
        .head_o      (p_head),
        .cnt_o       (p_cnt)
    );

    always_comb begin
        st_d = st_q;
        // write-1-to-clear first, new events win
        st_d.halted = st_q.halted & ~halt_clr_i;
        // disable request leaves the pending set once written
        if (gnt_v && (np_dok || p_dok)) st_d.dis_pend[gnt] = 1'b0;
        if (gnt_v) st_d.ptr = CHW'((int'(gnt) + 1) % NCH);
        if (dis_accept) st_d.dis_pend[cfg_ch_i] = 1'b1;
        // retirement of a disable entry
        for (int i = 0; i < NCH; i++) begin
            if (retire_dis && int'(head.ch) == i) begin
                if (st_q.mode) st_d.halted[i]    = 1'b1;
                else           st_d.stat_pend[i] = 1'b1;
            end
        end
        // software pops a status entry
        if (stat_pop_i && st_q.stat_pend[stat_pop_ch_i]) begin
            st_d.stat_pend[stat_pop_ch_i] = 1'b0;
            st_d.halted[stat_pop_ch_i]    = 1'b1;
        end
        if (cfg_we_i && !cfg_dis_i) st_d.ena[cfg_ch_i] = cfg_ena_i;
        st_d.ena = st_d.ena & ~st_d.halted;
        if (st_q.ena == '0 && st_q.dis_pend == '0 && st_q.stat_pend == '0)
            st_d.mode = dma_mode_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ch_ena_o    = st_q.ena;
    assign halted_o    = st_q.halted;
    assign rxflvl_o    = |st_q.stat_pend;
    assign dis_wr_np_o = np_dok;
    assign dis_wr_p_o  = p_dok;
    assign np_cnt_o    = np_cnt;
    assign p_cnt_o     = p_cnt;
    assign mode_dma_o  = st_q.mode;
endmodule

// File: rtl/hc_halt_ctrl_chk.sv
module hc_halt_ctrl_chk #(
    parameter int NCH   = 4,
    parameter int DEPTH = 4,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int CW  = $clog2(DEPTH + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           xact_busy_i,
    input logic           stat_pop_i,
    input logic [NCH-1:0] ch_ena_o,
    input logic [NCH-1:0] halted_o,
    input logic           dis_wr_np_o,
    input logic           dis_wr_p_o,
    input logic           issue_o,
    input logic [CW-1:0]  np_cnt_o,
    input logic [CW-1:0]  p_cnt_o,
    input logic           mode_dma_o
);
    assert_cnt_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(np_cnt_o) <= DEPTH) && (int'(p_cnt_o) <= DEPTH));

    assert_one_dis_wr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(dis_wr_np_o && dis_wr_p_o));

    assert_no_issue_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        xact_busy_i |-> !issue_o);

    assert_mode_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_ena_o) |=> $stable(mode_dma_o));

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assert_halt_ena_R9: assert property (@(posedge clk) disable iff (!rst_n)
            halted_o[g] |-> !ch_ena_o[g]);

        assert_dma_after_xact_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(halted_o[g]) && $past(mode_dma_o)) |-> $past(!xact_busy_i));

        assert_slave_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(halted_o[g]) && !$past(mode_dma_o)) |-> $past(stat_pop_i));
    end
endmodule

bind hc_halt_ctrl hc_halt_ctrl_chk #(.NCH(NCH), .DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .xact_busy_i (xact_busy_i),
    .stat_pop_i  (stat_pop_i),
    .ch_ena_o    (ch_ena_o),
    .halted_o    (halted_o),
    .dis_wr_np_o (dis_wr_np_o),
    .dis_wr_p_o  (dis_wr_p_o),
    .issue_o     (issue_o),
    .np_cnt_o    (np_cnt_o),
    .p_cnt_o     (p_cnt_o),
    .mode_dma_o  (mode_dma_o)
);

// File: tb/hc_halt_ctrl_bench.sv
module hc_halt_ctrl_bench;
    localparam int NCH = 4;
    localparam int DEPTH = 4;
    localparam int CHW = 2;
    localparam int CW = 3;
    localparam time TCLK = 10ns;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           dma_mode_i = 1'b0;
    logic [NCH-1:0] ch_per_i = 4'b1100;
    logic           cfg_we_i = 1'b0;
    logic [CHW-1:0] cfg_ch_i = '0;
    logic           cfg_ena_i = 1'b0;
    logic           cfg_dis_i = 1'b0;
    logic           post_we_i = 1'b0;
    logic [CHW-1:0] post_ch_i = '0;
    logic           xact_busy_i = 1'b0;
    logic           stat_pop_i = 1'b0;
    logic [CHW-1:0] stat_pop_ch_i = '0;
    logic [NCH-1:0] halt_clr_i = '0;
    logic [NCH-1:0] ch_ena_o, halted_o;
    logic           rxflvl_o, flush_o, dis_wr_np_o, dis_wr_p_o, issue_o, mode_dma_o;
    logic [CHW-1:0] issue_ch_o;
    logic [CW-1:0]  np_cnt_o, p_cnt_o;

    int vectors = 0;
    int miscompares = 0;
    int exp_q[$];
    logic [NCH-1:0] halted_prev = '0;

    always #(TCLK/2) clk = ~clk;

    hc_halt_ctrl #(.NCH(NCH), .DEPTH(DEPTH)) u_hc_halt_ctrl (.*);

    task automatic chk(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int ch, bit ena, bit dis);
        cfg_we_i = 1'b1; cfg_ch_i = CHW'(ch); cfg_ena_i = ena; cfg_dis_i = dis;
        @(negedge clk);
        cfg_we_i = 1'b0; cfg_ena_i = 1'b0; cfg_dis_i = 1'b0;
    endtask

    task automatic post(int ch);
        post_we_i = 1'b1; post_ch_i = CHW'(ch);
        @(negedge clk);
        post_we_i = 1'b0;
    endtask

    task automatic clr(int ch);
        halt_clr_i = '0; halt_clr_i[ch] = 1'b1;
        @(negedge clk);
        halt_clr_i = '0;
    endtask

    task automatic pop(int ch);
        stat_pop_i = 1'b1; stat_pop_ch_i = CHW'(ch);
        @(negedge clk);
        stat_pop_i = 1'b0;
    endtask

    // scoreboard monitor: each rising halted bit must match the queue front
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                if (halted_o[i] && !halted_prev[i]) begin
                    vectors++;
                    if (exp_q.size() == 0) begin
                        miscompares++;
                        $display("FAIL R6/R7 scoreboard: actual halt ch %0d expected none", i);
                    end else begin
                        int e;
                        e = exp_q.pop_front();
                        if (e != i) begin
                            miscompares++;
                            $display("FAIL R6/R7 scoreboard: actual halt ch %0d expected ch %0d", i, e);
                        end
                    end
                end
            end
        end
        halted_prev = halted_o;
    end

    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        cyc(2);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        chk("R1 ena", int'(ch_ena_o), 0);
        chk("R1 halted", int'(halted_o), 0);
        chk("R1 np_cnt", int'(np_cnt_o), 0);
        chk("R1 p_cnt", int'(p_cnt_o), 0);
        chk("R1 rxflvl", int'(rxflvl_o), 0);
        chk("R1 mode", int'(mode_dma_o), 0);

        // R10 mode taken while idle
        dma_mode_i = 1'b1;
        cyc(2);
        chk("R10 mode idle", int'(mode_dma_o), 1);
        wr(0, 1, 0);
        wr(1, 1, 0);
        dma_mode_i = 1'b0;
        cyc(3);
        chk("R10 mode held", int'(mode_dma_o), 1);
        dma_mode_i = 1'b1;

        // R2 flush with disable+enable, R4 write on turn, R5 busy hold
        xact_busy_i = 1'b1;
        post(0); post(1); post(0);
        chk("R2 np before", int'(np_cnt_o), 3);
        cfg_we_i = 1'b1; cfg_ch_i = 0; cfg_ena_i = 1'b1; cfg_dis_i = 1'b1;
        #1;
        chk("R2 flush pulse", int'(flush_o), 1);
        @(negedge clk);
        cfg_we_i = 1'b0; cfg_ena_i = 1'b0; cfg_dis_i = 1'b0;
        chk("R2 np after flush", int'(np_cnt_o), 1);
        exp_q.push_back(0);
        @(negedge clk);
        chk("R4 disable written", int'(np_cnt_o), 2);
        cyc(5);
        chk("R5 no halt while busy", int'(halted_o[0]), 0);
        chk("R5 np held", int'(np_cnt_o), 2);
        xact_busy_i = 1'b0;
        #1;
        chk("R5 issue ch1 first", int'(issue_o && issue_ch_o == 1), 1);
        cyc(4);
        chk("R6 halted ch0", int'(halted_o[0]), 1);
        chk("R9 ena cleared", int'(ch_ena_o[0]), 0);
        chk("R6 np empty", int'(np_cnt_o), 0);
        clr(0);
        chk("R9 halted cleared", int'(halted_o[0]), 0);

        // R3 disable-only flush
        xact_busy_i = 1'b1;
        post(1); post(1);
        chk("R3 np before", int'(np_cnt_o), 2);
        wr(1, 0, 1);
        cyc(3);
        chk("R3 np flushed no request", int'(np_cnt_o), 0);
        chk("R3 ena kept", int'(ch_ena_o[1]), 1);
        chk("R3 no halt", int'(halted_o[1]), 0);
        xact_busy_i = 1'b0;
        cyc(3);
        chk("R3 still no halt", int'(halted_o[1]), 0);

        // R4 DMA wait on full queue
        xact_busy_i = 1'b1;
        post(1); post(1); post(1); post(1);
        chk("R4 np full", int'(np_cnt_o), 4);
        wr(0, 1, 0);
        wr(0, 1, 1);
        exp_q.push_back(0);
        cyc(5);
        chk("R4 count held while full", int'(np_cnt_o), 4);
        chk("R4 no halt yet", int'(halted_o[0]), 0);
        xact_busy_i = 1'b0;
        cyc(12);
        chk("R4 halted after room", int'(halted_o[0]), 1);
        chk("R4 np drained", int'(np_cnt_o), 0);
        clr(0);

        // R6 periodic class
        wr(2, 1, 0);
        wr(2, 1, 1);
        exp_q.push_back(2);
        cyc(5);
        chk("R6 periodic halted", int'(halted_o[2]), 1);
        chk("R6 p empty", int'(p_cnt_o), 0);
        clr(2);

        // R7 slave mode pop-gated halt
        wr(1, 0, 0);
        dma_mode_i = 1'b0;
        cyc(2);
        chk("R10 mode slave", int'(mode_dma_o), 0);
        wr(0, 1, 0);
        wr(0, 1, 1);
        cyc(5);
        chk("R7 rxflvl", int'(rxflvl_o), 1);
        chk("R7 no halt before pop", int'(halted_o[0]), 0);
        exp_q.push_back(0);
        pop(0);
        chk("R7 halted on pop", int'(halted_o[0]), 1);
        chk("R7 rxflvl clear", int'(rxflvl_o), 0);
        clr(0);

        // R8 slave refusal on full queue
        wr(0, 1, 0);
        wr(1, 1, 0);
        xact_busy_i = 1'b1;
        post(1); post(1); post(1); post(1);
        wr(0, 1, 1);
        cyc(3);
        xact_busy_i = 1'b0;
        cyc(15);
        chk("R8 no status", int'(rxflvl_o), 0);
        chk("R8 no halt", int'(halted_o[0]), 0);
        chk("R8 ena kept", int'(ch_ena_o[0]), 1);
        chk("R8 np drained", int'(np_cnt_o), 0);

        // R7 pop of the wrong channel is ignored
        wr(1, 1, 1);
        cyc(5);
        chk("R7 rxflvl ch1", int'(rxflvl_o), 1);
        pop(0);
        chk("R7 wrong pop no halt", int'(halted_o[1]), 0);
        chk("R7 wrong pop keeps status", int'(rxflvl_o), 1);
        exp_q.push_back(1);
        pop(1);
        chk("R7 right pop halts", int'(halted_o[1]), 1);
        cyc(2);

        chk("R6/R7 scoreboard empty", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule